// File: doc/BRIEF.md
# Masked Vector-Indexed Prefetch Address Generator

This block takes one vector-indexed prefetch command and turns it into a sequence of single-address prefetch requests. A command supplies the following fields:

- a base register value and a flag that says whether a base is present;
- a 512-bit vector of packed indices and a 16-bit lane mask;
- a scale code and a signed displacement with a size code;
- an index-width/data-type mode and two address-form flags.

The block captures the command in one cycle. It then walks the enabled lanes from the lowest lane upward. For each one it offers a byte address on a valid/ready handshake.

Every request is tagged as a first-level-cache prefetch that seeks exclusive ownership. The arithmetic never faults. Addresses are passed through as raw byte addresses with no alignment or line-split handling.

Commands that use 16-bit effective addressing, or that lack an index byte in their memory operand encoding, are refused. The block reports them on an undefined-opcode pulse and issues no requests for them. When the last request of an accepted command has been taken, a one-cycle completion pulse follows.

Top module: `vidx_pf_agen`

## Requirements
- R1: `mode_i` selects the lane layout:
  - 0: 16 lanes, lane j using the 32-bit index at bits [32j+31:32j].
  - 1: 8 lanes, lane j using the low 32 bits of the 64-bit slot at [64j+63:64j].
  - 2: 8 lanes, lane j using the 32-bit index at [32j+31:32j], so only the low 256 bits are used.
  - 3: 8 lanes, lane j using the full 64-bit index at [64j+63:64j].
- R2: A request address equals base + signext(index) × 2^`scale_i` + displacement, computed modulo 2^64. `scale_i` is 0..3, standing for ×1, ×2, ×4 and ×8.
- R3: `disp_sz_i` sets the displacement term, and the chosen bytes are sign-extended to 64 bits:
  - 0: no displacement (zero).
  - 1: `disp_i[7:0]`.
  - 2: `disp_i[15:0]`.
  - 3: `disp_i[31:0]`.
- R4: When `base_en_i` is 0, the base term is zero whatever `base_i` holds.
- R5: Only lanes whose mask bit is 1 issue a request, in ascending lane order, one per accepted handshake. Mask bits at or above the mode's lane count are ignored.
- R6: Every request carries `req_level_o` = 0 and `req_excl_o` = 1.
- R7: A start with `addr16_i` = 1 or `no_sib_i` = 1 produces `ud_o` = 1 for exactly the cycle after the start. That command issues no request and no done pulse.
- R8: `done_o` is high for one cycle. That cycle is the one after the last enabled lane is accepted, or the cycle after the start when no lane is enabled.
- R9: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid and its address does not change.
- R10: A start that arrives while a command is in progress is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, taken only while idle |
| base_i | input | 64 | Base register value |
| base_en_i | input | 1 | Base present |
| idx_vec_i | input | 512 | Packed index vector |
| mask_i | input | 16 | Lane enable mask |
| scale_i | input | 2 | Scale as a shift amount (0..3) |
| disp_i | input | 32 | Displacement bits |
| disp_sz_i | input | 2 | Displacement size code |
| mode_i | input | 2 | Index width / data type mode |
| addr16_i | input | 1 | Command uses 16-bit effective addressing |
| no_sib_i | input | 1 | Memory operand lacks an index byte |
| req_valid_o | output | 1 | Prefetch request valid |
| req_ready_i | input | 1 | Prefetch request accepted |
| req_addr_o | output | 64 | Prefetch byte address |
| req_level_o | output | 2 | Target cache level (always 0) |
| req_excl_o | output | 1 | Exclusive ownership request (always 1) |
| done_o | output | 1 | Command complete pulse |
| ud_o | output | 1 | Undefined-opcode pulse |

## Verification
The bench sweeps every mode, scale, displacement size and base-present setting. It uses negative indices and masks that are sparse, full, empty and set only above the lane count.

- A wrong slot stride in the 64-bit modes, or reading beyond bit 255 in mode 2, shows up as mismatching addresses.
- A zero-extended index or displacement gives addresses near 2^32 instead of just below the base.
- Ignoring the lane limit would issue extra requests for high mask bits.
- Back-pressure is applied on every third cycle, so a design that advanced without a handshake would skip addresses.
- A stray start during a busy command shows whether the design restarted.
- Refused commands show whether requests leak out after an undefined-opcode report.

// File: rtl/vpf_pkg.sv
`timescale 1ns/1ps
package vpf_pkg;
  localparam int PF_AW     = 64;
  localparam int PF_VEC_W  = 512;
  localparam int PF_LANES  = 16;
  localparam int PF_DISP_W = 32;
  localparam int PF_LVL_W  = 2;
  localparam int PF_LIDX_W = $clog2(PF_LANES);

  typedef enum logic [1:0] {
    PF_D32_S = 2'd0,
    PF_Q64_S = 2'd1,
    PF_D32_D = 2'd2,
    PF_Q64_D = 2'd3
  } pf_mode_e;

  typedef enum logic [1:0] {
    DSP_NONE = 2'd0,
    DSP_B8   = 2'd1,
    DSP_B16  = 2'd2,
    DSP_B32  = 2'd3
  } pf_disp_e;

  // lanes that exist for a mode
  function automatic logic [PF_LANES-1:0] pf_mode_lanes(input pf_mode_e mode);
    logic [PF_LANES-1:0] m;
    if (mode == PF_D32_S) m = '1;
    else m = {{(PF_LANES/2){1'b0}}, {(PF_LANES/2){1'b1}}};
    return m;
  endfunction

  // pull one lane's index out of the packed vector, sign-extended
  function automatic logic [PF_AW-1:0] pf_lane_index(input logic [PF_VEC_W-1:0] vec,
                                                     input pf_mode_e mode,
                                                     input logic [PF_LIDX_W-1:0] lane);
    logic [31:0] w32;
    logic [63:0] w64;
    int l32;
    int l64;
    l32 = int'(lane);
    l64 = int'(lane[PF_LIDX_W-2:0]);
    w32 = '0;
    w64 = '0;
    case (mode)
      PF_D32_S, PF_D32_D: begin
        w32 = vec[32*l32 +: 32];
        w64 = {{32{w32[31]}}, w32};
      end
      PF_Q64_S: begin
        w32 = vec[64*l64 +: 32];
        w64 = {{32{w32[31]}}, w32};
      end
      default: w64 = vec[64*l64 +: 64];
    endcase
    return w64;
  endfunction

  function automatic logic [PF_AW-1:0] pf_disp_ext(input logic [PF_DISP_W-1:0] d,
                                                   input pf_disp_e sz);
    logic [PF_AW-1:0] r;
    case (sz)
      DSP_B8:  r = {{(PF_AW-8){d[7]}}, d[7:0]};
      DSP_B16: r = {{(PF_AW-16){d[15]}}, d[15:0]};
      DSP_B32: r = {{(PF_AW-32){d[31]}}, d[31:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [PF_AW-1:0] pf_lane_addr(input logic [PF_AW-1:0] base,
                                                    input logic base_en,
                                                    input logic [PF_AW-1:0] sidx,
                                                    input logic [1:0] scale,
                                                    input logic [PF_AW-1:0] dext);
    logic [PF_AW-1:0] b;
    b = base_en ? base : '0;
    return b + (sidx << scale) + dext;
  endfunction
endpackage

// File: rtl/vpf_lane_select.sv
`timescale 1ns/1ps
module vpf_lane_select #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end
  assign onehot_o = pend_i & (~pend_i + N'(1));
  assign found_o  = |pend_i;
endmodule

// File: rtl/vpf_addr_calc.sv
`timescale 1ns/1ps
module vpf_addr_calc
  import vpf_pkg::*;
(
  input  logic [PF_VEC_W-1:0]  vec_i,
  input  pf_mode_e             mode_i,
  input  logic [PF_LIDX_W-1:0] lane_i,
  input  logic [PF_AW-1:0]     base_i,
  input  logic                 base_en_i,
  input  logic [1:0]           scale_i,
  input  logic [PF_AW-1:0]     dext_i,
  output logic [PF_AW-1:0]     addr_o
);
  logic [PF_AW-1:0] sidx;
  assign sidx   = pf_lane_index(vec_i, mode_i, lane_i);
  assign addr_o = pf_lane_addr(base_i, base_en_i, sidx, scale_i, dext_i);
endmodule

// File: rtl/vpf_ctrl.sv
`timescale 1ns/1ps
module vpf_ctrl #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         bad_form_i,
  input  logic [N-1:0] lane_mask_i,
  input  logic         fire_i,
  input  logic [N-1:0] fire_onehot_i,
  output logic         busy_o,
  output logic [N-1:0] pend_o,
  output logic         take_o,
  output logic         done_o,
  output logic         ud_o
);
  logic         busy_q;
  logic [N-1:0] pend_q;
  logic         ud_q;
  logic         reject;

  assign take_o = start_i && !busy_q && !bad_form_i;
  assign reject = start_i && !busy_q && bad_form_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      ud_q   <= 1'b0;
    end else begin
      ud_q <= reject;
      if (take_o) begin
        busy_q <= 1'b1;
        pend_q <= lane_mask_i;
      end else if (busy_q) begin
        if (fire_i) pend_q <= pend_q & ~fire_onehot_i;
        if (pend_q == '0) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign pend_o = pend_q;
  assign done_o = busy_q && (pend_q == '0);
  assign ud_o   = ud_q;
endmodule

// File: rtl/vidx_pf_agen.sv
`timescale 1ns/1ps
module vidx_pf_agen
  import vpf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [PF_AW-1:0]     base_i,
  input  logic                 base_en_i,
  input  logic [PF_VEC_W-1:0]  idx_vec_i,
  input  logic [PF_LANES-1:0]  mask_i,
  input  logic [1:0]           scale_i,
  input  logic [PF_DISP_W-1:0] disp_i,
  input  logic [1:0]           disp_sz_i,
  input  logic [1:0]           mode_i,
  input  logic                 addr16_i,
  input  logic                 no_sib_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [PF_AW-1:0]     req_addr_o,
  output logic [PF_LVL_W-1:0]  req_level_o,
  output logic                 req_excl_o,
  output logic                 done_o,
  output logic                 ud_o
);
  // named events for the checker
  logic                 busy_w;
  logic [PF_LANES-1:0]  pend_w;
  logic                 cmd_take;
  logic                 lane_fire;
  logic                 lane_found;
  logic [PF_LIDX_W-1:0] lane_idx;
  logic [PF_LANES-1:0]  lane_onehot;
  logic                 bad_form;
  logic [PF_LANES-1:0]  gated_mask;

  // captured command
  logic [PF_VEC_W-1:0]  vec_q;
  pf_mode_e             mode_q;
  logic [PF_AW-1:0]     base_q;
  logic                 base_en_q;
  logic [1:0]           scale_q;
  logic [PF_AW-1:0]     dext_q;

  assign bad_form   = addr16_i || no_sib_i;
  assign gated_mask = mask_i & pf_mode_lanes(pf_mode_e'(mode_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q     <= '0;
      mode_q    <= PF_D32_S;
      base_q    <= '0;
      base_en_q <= 1'b0;
      scale_q   <= '0;
      dext_q    <= '0;
    end else if (cmd_take) begin
      vec_q     <= idx_vec_i;
      mode_q    <= pf_mode_e'(mode_i);
      base_q    <= base_i;
      base_en_q <= base_en_i;
      scale_q   <= scale_i;
      dext_q    <= pf_disp_ext(disp_i, pf_disp_e'(disp_sz_i));
    end
  end

  vpf_ctrl #(.N(PF_LANES)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .bad_form_i    (bad_form),
    .lane_mask_i   (gated_mask),
    .fire_i        (lane_fire),
    .fire_onehot_i (lane_onehot),
    .busy_o        (busy_w),
    .pend_o        (pend_w),
    .take_o        (cmd_take),
    .done_o        (done_o),
    .ud_o          (ud_o)
  );

  vpf_lane_select #(.N(PF_LANES)) u_sel (
    .pend_i   (pend_w),
    .found_o  (lane_found),
    .idx_o    (lane_idx),
    .onehot_o (lane_onehot)
  );

  vpf_addr_calc u_addr (
    .vec_i     (vec_q),
    .mode_i    (mode_q),
    .lane_i    (lane_idx),
    .base_i    (base_q),
    .base_en_i (base_en_q),
    .scale_i   (scale_q),
    .dext_i    (dext_q),
    .addr_o    (req_addr_o)
  );

  assign req_valid_o = busy_w && lane_found;
  assign lane_fire   = req_valid_o && req_ready_i;
  assign req_level_o = '0;
  assign req_excl_o  = 1'b1;
endmodule

// File: rtl/vidx_pf_agen_chk.sv
`timescale 1ns/1ps
module vidx_pf_agen_chk
  import vpf_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                req_valid_o,
  input logic                req_ready_i,
  input logic [PF_AW-1:0]    req_addr_o,
  input logic [PF_LVL_W-1:0] req_level_o,
  input logic                req_excl_o,
  input logic                done_o,
  input logic                ud_o,
  input logic                busy_w,
  input logic [PF_LANES-1:0] pend_w,
  input logic                lane_fire
);
  AST_REQ_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_level_o == '0) && req_excl_o); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o); // R8
  AST_UD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ud_o |-> !req_valid_o && !done_o); // R7
  AST_ONE_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lane_fire |=> $countones(pend_w) == $countones($past(pend_w)) - 1); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && start_i && !lane_fire |=> $stable(pend_w)); // R10
endmodule

bind vidx_pf_agen vidx_pf_agen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_level_o (req_level_o),
  .req_excl_o  (req_excl_o),
  .done_o      (done_o),
  .ud_o        (ud_o),
  .busy_w      (busy_w),
  .pend_w      (pend_w),
  .lane_fire   (lane_fire)
);

// File: tb/test_vidx_pf_agen.sv
`timescale 1ns/1ps
module test_vidx_pf_agen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [63:0]  base_i = '0;
  logic         base_en_i = 1'b0;
  logic [511:0] idx_vec_i = '0;
  logic [15:0]  mask_i = '0;
  logic [1:0]   scale_i = '0;
  logic [31:0]  disp_i = '0;
  logic [1:0]   disp_sz_i = '0;
  logic [1:0]   mode_i = '0;
  logic         addr16_i = 1'b0;
  logic         no_sib_i = 1'b0;
  logic         req_valid_o;
  logic         req_ready_i = 1'b0;
  logic [63:0]  req_addr_o;
  logic [1:0]   req_level_o;
  logic         req_excl_o;
  logic         done_o;
  logic         ud_o;

  int n_chk = 0;
  int n_err = 0;
  int tick = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tick++;

  vidx_pf_agen i_vidx_pf_agen (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model of one lane's address, written as signed arithmetic
  function automatic logic [63:0] model_addr(int lane);
    longint ix;
    longint dx;
    case (mode_i)
      2'd0, 2'd2: ix = longint'($signed(idx_vec_i[lane*32 +: 32]));
      2'd1:       ix = longint'($signed(idx_vec_i[lane*64 +: 32]));
      default:    ix = longint'($signed(idx_vec_i[lane*64 +: 64]));
    endcase
    case (disp_sz_i)
      2'd1:    dx = longint'($signed(disp_i[7:0]));
      2'd2:    dx = longint'($signed(disp_i[15:0]));
      2'd3:    dx = longint'($signed(disp_i[31:0]));
      default: dx = 0;
    endcase
    return (base_en_i ? base_i : 64'd0) + 64'(ix * (longint'(1) << scale_i)) + 64'(dx);
  endfunction

  task automatic run_cmd(input string tag, input bit bad, input bit poke);
    logic [63:0] exp_q[$];
    int lanes;
    int got;
    bit seen_done;
    lanes = (mode_i == 2'd0) ? 16 : 8;
    for (int j = 0; j < lanes; j++) if (mask_i[j]) exp_q.push_back(model_addr(j));
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    if (bad) begin
      chk(ud_o == 1'b1, {"R7 ud pulse ", tag}, 64'(ud_o), 64'd1);
      chk(!req_valid_o && !done_o, {"R7 no req/done ", tag}, {62'd0, req_valid_o, done_o}, 64'd0);
      @(negedge clk);
      chk(!ud_o && !req_valid_o && !done_o, {"R7 quiet after ", tag},
          {61'd0, ud_o, req_valid_o, done_o}, 64'd0);
      return;
    end
    got = 0;
    seen_done = 1'b0;
    for (int g = 0; g < 120 && !seen_done; g++) begin
      if (done_o) begin
        chk(got == exp_q.size(), {"R8 done after last ", tag}, 64'(got), 64'(exp_q.size()));
        seen_done = 1'b1;
      end else if (req_valid_o) begin
        if (got < exp_q.size())
          chk(req_addr_o == exp_q[got], {"R2/R5 address ", tag}, req_addr_o, exp_q[got]);
        else
          chk(1'b0, {"R5 extra request ", tag}, req_addr_o, 64'd0);
        chk(req_level_o == 2'd0 && req_excl_o, {"R6 tags ", tag}, {61'd0, req_level_o, req_excl_o}, 64'd1);
        if (tick % 3 != 0) begin
          req_ready_i = 1'b1;
          got++;
        end
        if (poke && g == 1) begin
          start_i = 1'b1;
          mask_i  = ~mask_i;
          mode_i  = mode_i ^ 2'd3;
        end
      end else begin
        chk(1'b0, {"R8 idle before done ", tag}, 64'd0, 64'd1);
      end
      @(negedge clk);
      req_ready_i = 1'b0;
      start_i = 1'b0;
    end
    chk(seen_done, {"R8 done seen ", tag}, 64'(seen_done), 64'd1);
    chk(!done_o && !req_valid_o, {"R8 one-cycle done ", tag}, {62'd0, done_o, req_valid_o}, 64'd0);
  endtask

  task automatic fill_vec();
    for (int k = 0; k < 16; k++) idx_vec_i[k*32 +: 32] = $urandom();
    idx_vec_i[31:0]  = 32'hFFFF_FFF0;   // negative index
    idx_vec_i[63:32] = 32'h8000_0000;   // most negative
  endtask

  initial begin
    #2_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] masks [5];
    masks = '{16'hFFFF, 16'h0000, 16'h8001, 16'hA5A5, 16'hFF00};
    repeat (3) @(negedge clk);
    chk(!req_valid_o && !done_o && !ud_o, "reset outputs idle", {61'd0, req_valid_o, done_o, ud_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid_o && !done_o && !ud_o, "after reset idle", {61'd0, req_valid_o, done_o, ud_o}, 64'd0);

    // R1 R2 R3 R4 R5: sweep of modes, scales, displacement sizes, base presence
    for (int md = 0; md < 4; md++)
      for (int sc = 0; sc < 4; sc++)
        for (int dz = 0; dz < 4; dz++)
          for (int be = 0; be < 2; be++) begin
            fill_vec();
            mode_i    = 2'(md);
            scale_i   = 2'(sc);
            disp_sz_i = 2'(dz);
            base_en_i = be[0];
            base_i    = {$urandom(), $urandom()};
            disp_i    = (dz % 2 == 0) ? 32'hFFFF_8F80 : 32'h0000_7F7F;
            mask_i    = masks[(md + sc + dz + be) % 5];
            run_cmd($sformatf("R1 R3 R4 m%0d s%0d d%0d b%0d", md, sc, dz, be), 1'b0, 1'b0);
          end

    // R5: high mask bits ignored in 8-lane modes
    mode_i = 2'd3; mask_i = 16'hFF00;
    run_cmd("R5 high bits only", 1'b0, 1'b0);

    // R2: wrap modulo 2^64
    mode_i = 2'd3; scale_i = 2'd3; disp_sz_i = 2'd3; disp_i = 32'h7FFF_FFFF;
    base_en_i = 1'b1; base_i = 64'hFFFF_FFFF_FFFF_FFF0; mask_i = 16'h0003;
    idx_vec_i[63:0] = 64'h7FFF_FFFF_FFFF_FFFF;
    run_cmd("R2 wrap", 1'b0, 1'b0);

    // R10: start while busy is ignored
    fill_vec(); mode_i = 2'd0; mask_i = 16'hFFFF; scale_i = 2'd2; disp_sz_i = 2'd1;
    run_cmd("R10 busy start", 1'b0, 1'b1);

    // R7: refused forms
    mode_i = 2'd0; mask_i = 16'hFFFF;
    addr16_i = 1'b1; run_cmd("R7 addr16", 1'b1, 1'b0);
    addr16_i = 1'b0; no_sib_i = 1'b1; run_cmd("R7 nosib", 1'b1, 1'b0);
    addr16_i = 1'b1; run_cmd("R7 both", 1'b1, 1'b0);
    addr16_i = 1'b0; no_sib_i = 1'b0;
    run_cmd("R7 recover", 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule